// File: doc/BRIEF.md
# Flow-Control Pause Frame Receive Detector

This block sits on the receive side of a full-duplex Ethernet MAC and watches each incoming frame as a stream of bytes. It decides whether the frame is a flow-control PAUSE request. If it is, the block raises a single-cycle pulse and presents the 16-bit pause duration carried in the frame. That duration goes to a separate pause timer, which is not part of this block.

A frame is bracketed by a start strobe, which comes with its first byte, and an end strobe. The end strobe may come with the last byte or in a later cycle. A good/bad status from the MAC's CRC and length checks is sampled together with the end strobe. The destination, type and opcode fields are compared byte by byte as they arrive. The verdict is given only once the end status is known.

Top module: `pause_rx_detect`

## Requirements
- R1: After reset, `pause_o` is 0 and `pause_quanta_o` is 0x0000.
- R2: A frame whose bytes 0..5 are 01 80 C2 00 00 01, bytes 12..13 are 88 08, bytes 14..15 are 00 01, and which has at least 18 bytes and good status, produces `pause_o` high for exactly one cycle. That cycle is the cycle after `rx_eof_i`. In the same cycle `pause_quanta_o` equals {byte 16, byte 17}.
- R3: The destination (bytes 0..5, first byte on the wire is bits 47:40) is accepted only when it equals the reserved multicast address or `station_addr_i`. Any other destination gives no pulse.
- R4: Bytes 12..13 must be 0x88 then 0x08, or no pulse is given.
- R5: Bytes 14..15 must be 0x00 then 0x01, or no pulse is given.
- R6: A pulse is given only if `fdx_en_i` and `fc_en_i` are both high in the `rx_eof_i` cycle.
- R7: A pulse is given only if `rx_good_i` is high in the `rx_eof_i` cycle.
- R8: A frame with fewer than 18 bytes never gives a pulse. A byte that arrives together with `rx_eof_i` counts as the frame's last byte.
- R9: The source address (bytes 6..11), bytes after byte 17, and idle cycles with `rx_valid_i` low inside a frame do not affect the verdict.
- R10: `pause_quanta_o` changes only on a pulse and holds between pulses. Any duration from 0x0000 to 0xFFFF is passed through.
- R11: Bytes outside a frame (after `rx_eof_i` and before the next `rx_sof_i`) are ignored, and an `rx_eof_i` outside a frame gives no pulse.
- R12: An `rx_sof_i` in the middle of a frame abandons that frame and starts matching afresh at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_sof_i | input | 1 | Start of frame, comes with byte 0 |
| rx_valid_i | input | 1 | `rx_data_i` carries a byte |
| rx_data_i | input | 8 | Received byte |
| rx_eof_i | input | 1 | End of frame strobe |
| rx_good_i | input | 1 | Frame status, sampled with `rx_eof_i` |
| station_addr_i | input | 48 | Station unicast address, wire byte 0 in bits 47:40 |
| fdx_en_i | input | 1 | Full-duplex mode enable |
| fc_en_i | input | 1 | Flow-control detection enable |
| pause_o | output | 1 | One-cycle pause-detected pulse |
| pause_quanta_o | output | 16 | Duration captured from the last detected pause |

## Verification
The bench targets the boundaries where a wrong design would misbehave.

- **Length boundary.** It sends a 17-byte frame and an 18-byte frame whose last byte comes with the end strobe. A design that counted the wrong number of bytes, or dropped the byte that comes with the end strobe, would wrongly report the first or miss the second.
- **Field mismatches.** It sends frames with a single wrong byte in the destination, type or opcode. A design that failed to clear its match flag, or that checked only one of the two accepted addresses, would give a false pulse.
- **Mid-frame restart.** It restarts a frame in its middle. A design that kept stale flags or a stale byte count would give a pulse for the wrong frame or miss the right one.
- **Gates and status.** It turns off each enable and sends a bad status.
- **Out-of-frame traffic.** It sends bytes outside any frame.
- **Duration edge values.** It sends durations of 0x0000 and 0xFFFF, and checks that the duration output holds between pulses. A design with a loose output register would change the duration without a pulse.

// File: rtl/pause_det_pkg.sv
package pause_det_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int DA_FIRST   = 0;
  localparam int TYPE_FIRST = 12;
  localparam int OP_FIRST   = 14;
  localparam int DUR_FIRST  = 16;
  localparam int MIN_BYTES  = 18;

  localparam logic [47:0] RSV_ADDR   = 48'h0180_C200_0001;
  localparam logic [15:0] PAUSE_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OP   = 16'h0001;

  function automatic logic [7:0] be_byte48(input logic [47:0] v, input int k);
    return v[47 - 8*k -: 8];
  endfunction

  function automatic logic [7:0] be_byte16(input logic [15:0] v, input int k);
    return v[15 - 8*k -: 8];
  endfunction
endpackage

// File: rtl/pause_frame_track.sv
module pause_frame_track #(
  parameter int MIN_BYTES = 18,
  localparam int CNT_W = $clog2(MIN_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             valid_i,
  input  logic             eof_i,
  output logic             take_o,
  output logic             open_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             len_ok_o
);
  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_n;

  assign open_o   = sof_i | in_frame_q;
  assign take_o   = valid_i & open_o;
  assign cnt_base = sof_i ? '0 : cnt_q;
  assign idx_o    = cnt_base;

  // saturate at the minimum length; later bytes need no index
  always_comb begin
    cnt_n = cnt_base;
    if (take_o && (int'(cnt_base) < MIN_BYTES)) cnt_n = cnt_base + 1'b1;
  end

  assign len_ok_o = int'(cnt_n) >= MIN_BYTES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      in_frame_q <= open_o & ~eof_i;
      cnt_q      <= cnt_n;
    end
  end
endmodule

// File: rtl/pause_field_match.sv
module pause_field_match
  import pause_det_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  logic [47:0]      station_addr_i,
  output logic             match_o
);
  logic [ADDR_BYTES-1:0] rsv_hit, own_hit;
  logic rsv_q, own_q, ctl_q;
  logic rsv_b, own_b, ctl_b;
  logic rsv_n, own_n, ctl_n;

  // one comparator pair per destination byte
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_da
    assign rsv_hit[g] = (data_i == be_byte48(RSV_ADDR, g));
    assign own_hit[g] = (data_i == be_byte48(station_addr_i, g));
  end

  assign rsv_b = restart_i | rsv_q;
  assign own_b = restart_i | own_q;
  assign ctl_b = restart_i | ctl_q;

  always_comb begin
    rsv_n = rsv_b;
    own_n = own_b;
    ctl_n = ctl_b;
    if (take_i) begin
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (int'(idx_i) == DA_FIRST + k) begin
          rsv_n = rsv_b & rsv_hit[k];
          own_n = own_b & own_hit[k];
        end
      end
      for (int k = 0; k < 2; k++) begin
        if (int'(idx_i) == TYPE_FIRST + k)
          ctl_n = ctl_b & (data_i == be_byte16(PAUSE_TYPE, k));
        if (int'(idx_i) == OP_FIRST + k)
          ctl_n = ctl_b & (data_i == be_byte16(PAUSE_OP, k));
      end
    end
  end

  assign match_o = (rsv_n | own_n) & ctl_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsv_q <= 1'b1;
      own_q <= 1'b1;
      ctl_q <= 1'b1;
    end else begin
      rsv_q <= rsv_n;
      own_q <= own_n;
      ctl_q <= ctl_n;
    end
  end
endmodule

// File: rtl/pause_quanta_grab.sv
module pause_quanta_grab
  import pause_det_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [15:0]      dur_o
);
  logic [15:0] dur_q, dur_n;

  always_comb begin
    dur_n = restart_i ? 16'h0 : dur_q;
    if (take_i && int'(idx_i) == DUR_FIRST)     dur_n[15:8] = data_i;
    if (take_i && int'(idx_i) == DUR_FIRST + 1) dur_n[7:0]  = data_i;
  end

  assign dur_o = dur_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dur_q <= '0;
    else         dur_q <= dur_n;
  end
endmodule

// File: rtl/pause_rx_detect.sv
module pause_rx_detect
  import pause_det_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_sof_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_eof_i,
  input  logic        rx_good_i,
  input  logic [47:0] station_addr_i,
  input  logic        fdx_en_i,
  input  logic        fc_en_i,
  output logic        pause_o,
  output logic [15:0] pause_quanta_o
);
  localparam int CNT_W = $clog2(MIN_BYTES + 1);

  logic             take, open, len_ok, match;
  logic [CNT_W-1:0] idx;
  logic [15:0]      dur;
  logic             fire;
  logic             pause_q;
  logic [15:0]      quanta_q;

  pause_frame_track #(.MIN_BYTES(MIN_BYTES)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sof_i   (rx_sof_i),
    .valid_i (rx_valid_i),
    .eof_i   (rx_eof_i),
    .take_o  (take),
    .open_o  (open),
    .idx_o   (idx),
    .len_ok_o(len_ok)
  );

  pause_field_match #(.CNT_W(CNT_W)) u_match (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restart_i     (rx_sof_i),
    .take_i        (take),
    .idx_i         (idx),
    .data_i        (rx_data_i),
    .station_addr_i(station_addr_i),
    .match_o       (match)
  );

  pause_quanta_grab #(.CNT_W(CNT_W)) u_grab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(rx_sof_i),
    .take_i   (take),
    .idx_i    (idx),
    .data_i   (rx_data_i),
    .dur_o    (dur)
  );

  assign fire = rx_eof_i & open & fdx_en_i & fc_en_i & rx_good_i & len_ok & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q  <= 1'b0;
      quanta_q <= '0;
    end else begin
      pause_q <= fire;
      if (fire) quanta_q <= dur;
    end
  end

  assign pause_o        = pause_q;
  assign pause_quanta_o = quanta_q;
endmodule

// File: rtl/pause_rx_detect_chk.sv
module pause_rx_detect_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_eof_i,
  input logic        rx_good_i,
  input logic        fdx_en_i,
  input logic        fc_en_i,
  input logic        pause_o,
  input logic [15:0] pause_quanta_o
);
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |=> !pause_o);

  assert_after_eof_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> $past(rx_eof_i));

  assert_enables_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> $past(fdx_en_i && fc_en_i));

  assert_good_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> $past(rx_good_i));

  assert_quanta_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_o |-> $stable(pause_quanta_o));
endmodule

bind pause_rx_detect pause_rx_detect_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_eof_i      (rx_eof_i),
  .rx_good_i     (rx_good_i),
  .fdx_en_i      (fdx_en_i),
  .fc_en_i       (fc_en_i),
  .pause_o       (pause_o),
  .pause_quanta_o(pause_quanta_o)
);

// File: tb/pause_rx_detect_test.sv
module pause_rx_detect_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_sof_i = 1'b0, rx_valid_i = 1'b0, rx_eof_i = 1'b0, rx_good_i = 1'b0;
  logic [7:0]  rx_data_i = 8'h0;
  logic [47:0] station_addr_i = 48'h02_11_22_33_44_55;
  logic        fdx_en_i = 1'b1, fc_en_i = 1'b1;
  logic        pause_o;
  logic [15:0] pause_quanta_o;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0]  frm_q[$];
  logic [7:0]  tx_q[$];
  bit          m_in = 0;
  bit          pend = 0;
  logic [15:0] pend_q = 0;
  bit          exp_pause = 0;
  logic [15:0] exp_q = 0;

  always #10 clk = ~clk;

  pause_rx_detect uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_sof_i(rx_sof_i), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .rx_eof_i(rx_eof_i), .rx_good_i(rx_good_i),
    .station_addr_i(station_addr_i), .fdx_en_i(fdx_en_i), .fc_en_i(fc_en_i),
    .pause_o(pause_o), .pause_quanta_o(pause_quanta_o)
  );

  function automatic bit model_verdict(bit good);
    logic [47:0] da;
    if (!(fdx_en_i && fc_en_i && good)) return 0;
    if (frm_q.size() < 18) return 0;
    da = {frm_q[0], frm_q[1], frm_q[2], frm_q[3], frm_q[4], frm_q[5]};
    if (da != 48'h0180_C200_0001 && da != station_addr_i) return 0;
    if ({frm_q[12], frm_q[13]} != 16'h8808) return 0;
    if ({frm_q[14], frm_q[15]} != 16'h0001) return 0;
    return 1;
  endfunction

  // one bus cycle; the model advances alongside the design
  task automatic cyc(bit sof, bit vld, logic [7:0] d, bit eof, bit good);
    @(posedge clk); #1;
    exp_pause = pend;
    if (pend) exp_q = pend_q;
    pend = 0;
    rx_sof_i = sof; rx_valid_i = vld; rx_data_i = d; rx_eof_i = eof; rx_good_i = good;
    if (sof) begin frm_q.delete(); m_in = 1; end
    if (vld && m_in) frm_q.push_back(d);
    if (eof && m_in) begin
      pend = model_verdict(good);
      if (pend) pend_q = {frm_q[16], frm_q[17]};
      m_in = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0);
  endtask

  task automatic build(logic [47:0] da, logic [15:0] ty, logic [15:0] op, logic [15:0] q, int pad);
    tx_q.delete();
    for (int i = 0; i < 6; i++) tx_q.push_back(da[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) tx_q.push_back(8'hA0 + 8'(i * 7));
    tx_q.push_back(ty[15:8]); tx_q.push_back(ty[7:0]);
    tx_q.push_back(op[15:8]); tx_q.push_back(op[7:0]);
    tx_q.push_back(q[15:8]);  tx_q.push_back(q[7:0]);
    for (int i = 0; i < pad; i++) tx_q.push_back(8'(i * 13 + 5));
  endtask

  // eof_last: end strobe comes with the last byte; gaps: idle beats between bytes
  task automatic send(bit good, bit eof_last, bit gaps);
    for (int i = 0; i < tx_q.size(); i++) begin
      bit last = (i == tx_q.size() - 1);
      cyc(i == 0, 1, tx_q[i], last && eof_last, good);
      if (gaps && (i % 3 == 1) && !last) cyc(0, 0, 8'hEE, 0, 0);
    end
    if (!eof_last) cyc(0, 0, 8'h00, 1, good);
    idle(3);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_ni) begin
      total++;
      if (pause_o !== exp_pause || pause_quanta_o !== exp_q) begin
        bad++;
        $display("FAIL %s: pause=%0b quanta=%h expected pause=%0b quanta=%h",
                 cur_req, pause_o, pause_quanta_o, exp_pause, exp_q);
      end
    end
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    $display("FAIL watchdog: cycles=%0d expected finish", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    total++;
    if (pause_o !== 1'b0 || pause_quanta_o !== 16'h0) begin
      bad++;
      $display("FAIL R1: pause=%0b quanta=%h expected 0/0000", pause_o, pause_quanta_o);
    end
    rst_ni = 1'b1;
    idle(2);

    cur_req = "R2";  build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h1234, 0); send(1, 0, 0);
    cur_req = "R3";  build(station_addr_i,  16'h8808, 16'h0001, 16'hFFFF, 2); send(1, 1, 0);
    cur_req = "R3";  build(48'h0180C2000002, 16'h8808, 16'h0001, 16'h0BAD, 0); send(1, 0, 0);
    cur_req = "R3";  build(48'h02112233445F, 16'h8808, 16'h0001, 16'h0BAD, 0); send(1, 0, 0);
    cur_req = "R4";  build(48'h0180C2000001, 16'h8809, 16'h0001, 16'h0BAD, 0); send(1, 0, 0);
    cur_req = "R4";  build(48'h0180C2000001, 16'h0808, 16'h0001, 16'h0BAD, 0); send(1, 0, 0);
    cur_req = "R5";  build(48'h0180C2000001, 16'h8808, 16'h0101, 16'h0BAD, 0); send(1, 0, 0);
    cur_req = "R6";  fdx_en_i = 0; build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h0BAD, 0); send(1, 0, 0);
    fdx_en_i = 1; fc_en_i = 0;     build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h0BAD, 0); send(1, 0, 0);
    fc_en_i = 1;
    cur_req = "R7";  build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h0BAD, 0); send(0, 1, 0);
    cur_req = "R8";  build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h0BAD, 0);
    void'(tx_q.pop_back()); send(1, 0, 0);
    cur_req = "R8";  build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h0000, 0); send(1, 1, 0);
    cur_req = "R9";  build(station_addr_i, 16'h8808, 16'h0001, 16'hBEEF, 46); send(1, 0, 1);
    cur_req = "R10"; build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h0000, 4); send(1, 0, 0);
    idle(5);
    cur_req = "R11";
    for (int i = 0; i < 20; i++) cyc(0, 1, 8'h01, 0, 1);
    cyc(0, 0, 8'h00, 1, 1);
    idle(3);
    cur_req = "R12";
    build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h5A5A, 0);
    for (int i = 0; i < 10; i++) cyc(i == 0, 1, 8'h33, 0, 1);
    send(1, 0, 0);
    build(48'h0180C2000001, 16'h8808, 16'h0001, 16'h7777, 0);
    for (int i = 0; i < 14; i++) cyc(i == 0, 1, tx_q[i], 0, 1);
    build(48'h0180C2000001, 16'h8808, 16'h0002, 16'h0BAD, 0);
    send(1, 0, 0);
    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule